// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This block is the multiply stage of a 32-bit processor datapath. It takes two source operands, an accumulator operand and a 4-bit operation code. In response it produces a low result word, a high result word and a sticky saturation flag. Three families of operation are supported:

- Halfword-by-halfword multiplies. The top or bottom half of each operand is chosen on its own, and an accumulate step is optional.
- A word-by-halfword multiply-accumulate that keeps the upper product bits.
- A signed 32x32 long multiply whose 64-bit product is split across the two result words.

When an accumulating operation overflows, the sticky flag is set. The result itself is written unsaturated.

A two-state control machine sequences the work. In `ST_IDLE` no result is being presented. A cycle with `in_valid` high moves the machine to `ST_DONE` (transition *accept*). A further valid cycle keeps it in `ST_DONE` (transition *chain*). A cycle with no valid returns it to `ST_IDLE` (transition *retire*). Results are captured on the accepting edge and held until the next accepted operation. `out_done` is high exactly while the machine is in `ST_DONE`.

The flag can be cleared, or written directly, by a status-register update. An overflow raised in the same cycle overrides both of these.

Top module: `dsp_mac_unit`

## Requirements
- R1: After reset, `out_done`, `res_lo`, `res_hi` and `q_flag` are all zero.
- R2: `out_done` is high in the cycle after each cycle with `in_valid` high, and only then. The result words are updated on that same edge and are held while `in_valid` is low.
- R3: Codes 0 to 3 multiply a sign-extended halfword of `src_a` by a sign-extended halfword of `src_b`. Code bit 1 selects `src_a[31:16]` when it is 1 and `src_a[15:0]` when it is 0. Code bit 0 makes the same choice for `src_b`. `res_lo` receives the 32-bit signed product.
- R4: Codes 4 to 7 select halfwords in the same way, using code bits 1 and 0. They add the signed `acc_in` to the product, and `res_lo` receives the low 32 bits of the sum.
- R5: An accumulate overflows when bit 32 of the 33-bit sign-extended sum differs from bit 31. An overflow sets `q_flag`. The flag stays set until it is cleared or written, and the result is never saturated.
- R6: Code 8 (using `src_b[15:0]`) and code 9 (using `src_b[31:16]`) work as follows. The full signed `src_a` is multiplied by the sign-extended halfword. The signed `acc_in` shifted left by 16 is added, and the total is shifted arithmetically right by 16. `res_lo` receives bits 31:0 of that result, and the test of R5 is applied to its bits 32 and 31.
- R7: Code 10 forms the signed 64-bit product of `src_a` and `src_b`. `res_lo` receives bits 31:0 and `res_hi` receives bits 63:32.
- R8: Codes 0 to 3 never change `q_flag`.
- R9: Codes 11 to 15 produce zero in both result words and leave `q_flag` unchanged.
- R10: On each edge, an overflow from an accepted operation sets `q_flag`. Otherwise `q_clear` clears the flag. Otherwise `q_wr_en` loads `q_wr_val`.
- R11: Every code other than 10 writes zero to `res_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Start an operation this cycle |
| op_sel | input | 4 | Operation code |
| src_a | input | 32 | First multiply operand |
| src_b | input | 32 | Second multiply operand |
| acc_in | input | 32 | Accumulator operand |
| q_clear | input | 1 | Synchronous clear of the saturation flag |
| q_wr_en | input | 1 | Direct write enable for the saturation flag |
| q_wr_val | input | 1 | Value loaded by a direct write |
| out_done | output | 1 | Result valid pulse, one cycle after `in_valid` |
| res_lo | output | 32 | Low result word |
| res_hi | output | 32 | High result word (long multiply only) |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The halfword codes are driven with operands whose two halves differ in both sign and magnitude. A swapped pairing in the mixed top/bottom variants, or a missing sign extension, therefore gives a different product. The accumulate and word-by-halfword codes are driven with sums chosen to land just inside and just outside the signed 32-bit range. These cases separate a correct bit-32 test from a missing one and show that the result still wraps. Long multiplies with mixed signs expose a high word that was computed without sign extension. Flag traffic is placed in the same cycles as overflows to confirm that a set beats a clear and beats a write.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_MULL = 4'd10;

    typedef enum logic [2:0] {
        CL_MUL16,
        CL_MAC16,
        CL_MACW,
        CL_MULL,
        CL_NONE
    } op_class_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_DONE
    } mac_state_e;

    function automatic op_class_e op_class(input logic [OP_W-1:0] op);
        if (op < 4'd4)
            return CL_MUL16;
        else if (op < 4'd8)
            return CL_MAC16;
        else if (op < 4'd10)
            return CL_MACW;
        else if (op == OP_MULL)
            return CL_MULL;
        else
            return CL_NONE;
    endfunction

endpackage

// File: rtl/mac_half_sel.sv
module mac_half_sel #(
    parameter int W = 32
) (
    input  logic [W-1:0]   word_in,
    input  logic           take_top,
    output logic [W/2-1:0] half_out
);
    localparam int H = W / 2;

    assign half_out = take_top ? word_in[W-1:H] : word_in[H-1:0];

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import dsp_mac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    acc,
    output logic [W-1:0]    lo,
    output logic [W-1:0]    hi,
    output logic            ovf
);
    localparam int H  = W / 2;
    localparam int PW = W + H;
    localparam int LW = 2 * W;

    logic [W-1:0] opnd  [2];
    logic         top_q [2];
    logic [H-1:0] half  [2];

    assign opnd[0]  = a;
    assign opnd[1]  = b;
    assign top_q[0] = op[1];
    assign top_q[1] = op[0];

    for (genvar i = 0; i < 2; i++) begin : g_sel
        mac_half_sel #(.W(W)) u_sel (
            .word_in (opnd[i]),
            .take_top(top_q[i]),
            .half_out(half[i])
        );
    end

    // halfword x halfword, optional accumulate on a 33-bit sum
    logic [W-1:0]        ha_x, hb_x;
    logic signed [W-1:0] prod16;
    logic [W:0]          sum16;

    assign ha_x   = {{H{half[0][H-1]}}, half[0]};
    assign hb_x   = {{H{half[1][H-1]}}, half[1]};
    assign prod16 = $signed(ha_x) * $signed(hb_x);
    assign sum16  = {prod16[W-1], prod16} + {acc[W-1], acc};

    // word x halfword with accumulator pre-shifted by H, result >>> H
    logic [PW-1:0]        aw_x, bw_x;
    logic signed [PW-1:0] prodw;
    logic [PW:0]          sumw;
    logic [W:0]           shw;

    assign aw_x  = {{H{a[W-1]}}, a};
    assign bw_x  = {{W{half[1][H-1]}}, half[1]};
    assign prodw = $signed(aw_x) * $signed(bw_x);
    assign sumw  = {prodw[PW-1], prodw} + {acc[W-1], acc, {H{1'b0}}};
    assign shw   = sumw[PW:H];

    // full signed long multiply
    logic [LW-1:0]        al_x, bl_x;
    logic signed [LW-1:0] prodl;

    assign al_x  = {{W{a[W-1]}}, a};
    assign bl_x  = {{W{b[W-1]}}, b};
    assign prodl = $signed(al_x) * $signed(bl_x);

    always_comb begin
        lo  = '0;
        hi  = '0;
        ovf = 1'b0;
        unique case (op_class(op))
            CL_MUL16: lo = prod16;
            CL_MAC16: begin
                lo  = sum16[W-1:0];
                ovf = sum16[W] ^ sum16[W-1];
            end
            CL_MACW: begin
                lo  = shw[W-1:0];
                ovf = shw[W] ^ shw[W-1];
            end
            CL_MULL: begin
                lo = prodl[W-1:0];
                hi = prodl[LW-1:W];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mac_qflag.sv
module mac_qflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic wr_en,
    input  logic wr_val,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
        else if (wr_en)
            q <= wr_val;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

    assert_q_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> $past(clr || (wr_en && !wr_val)));

endmodule

// File: rtl/dsp_mac_unit.sv
module dsp_mac_unit
    import dsp_mac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              q_clear,
    input  logic              q_wr_en,
    input  logic              q_wr_val,
    output logic              out_done,
    output logic [DATA_W-1:0] res_lo,
    output logic [DATA_W-1:0] res_hi,
    output logic              q_flag
);
    mac_state_e state, state_nx;

    logic [DATA_W-1:0] dp_lo, dp_hi;
    logic              dp_ovf;

    mac_datapath #(.W(DATA_W)) u_dp (
        .op (op_sel),
        .a  (src_a),
        .b  (src_b),
        .acc(acc_in),
        .lo (dp_lo),
        .hi (dp_hi),
        .ovf(dp_ovf)
    );

    mac_qflag u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (in_valid && dp_ovf),
        .clr   (q_clear),
        .wr_en (q_wr_en),
        .wr_val(q_wr_val),
        .q     (q_flag)
    );

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_nx = in_valid ? ST_DONE : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
        end else if (in_valid) begin
            res_lo <= dp_lo;
            res_hi <= dp_hi;
        end
    end

    assign out_done = (state == ST_DONE);

    assert_done_after_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);

    assert_done_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $past(in_valid));

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_lo) && $stable(res_hi)));

    assert_hi_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != OP_MULL) |=> (res_hi == '0));

    assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class(op_sel) == CL_NONE) |=> (res_lo == '0 && res_hi == '0));

    assert_no_q_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class(op_sel) inside {CL_MUL16, CL_MULL, CL_NONE}
         && !q_clear && !q_wr_en) |=> (q_flag == $past(q_flag)));

endmodule

// File: tb/tb_dsp_mac_unit.sv
`timescale 1ns/1ps
module tb_dsp_mac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] src_a = '0, src_b = '0, acc_in = '0;
    logic        q_clear = 1'b0, q_wr_en = 1'b0, q_wr_val = 1'b0;
    logic        out_done, q_flag;
    logic [31:0] res_lo, res_hi;

    int checks = 0;
    int fails  = 0;

    logic        m_done = 1'b0, m_q = 1'b0;
    logic [31:0] m_lo = '0, m_hi = '0;

    localparam longint MAXI = 64'sh7FFF_FFFF;
    localparam longint MINI = -MAXI - 1;

    always #2.5 clk = ~clk;

    dsp_mac_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .q_clear(q_clear), .q_wr_en(q_wr_en), .q_wr_val(q_wr_val),
        .out_done(out_done), .res_lo(res_lo), .res_hi(res_hi), .q_flag(q_flag)
    );

    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] acc,
                         output logic [31:0] lo, output logic [31:0] hi, output logic ov);
        logic [15:0] ha, hb;
        longint s;
        ha = op[1] ? a[31:16] : a[15:0];
        hb = op[0] ? b[31:16] : b[15:0];
        lo = '0; hi = '0; ov = 1'b0;
        if (op < 4) begin
            s  = longint'($signed(ha)) * longint'($signed(hb));
            lo = s[31:0];
        end else if (op < 8) begin
            s  = longint'($signed(ha)) * longint'($signed(hb)) + longint'($signed(acc));
            lo = s[31:0];
            ov = (s > MAXI) || (s < MINI);
        end else if (op < 10) begin
            s  = longint'($signed(a)) * longint'($signed(hb)) + longint'($signed(acc)) * 65536;
            s  = s >>> 16;
            lo = s[31:0];
            ov = (s > MAXI) || (s < MINI);
        end else if (op == 10) begin
            s  = longint'($signed(a)) * longint'($signed(b));
            lo = s[31:0];
            hi = s[63:32];
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (out_done !== m_done || res_lo !== m_lo || res_hi !== m_hi || q_flag !== m_q) begin
            fails++;
            $display("FAIL %s: got done=%0b lo=%h hi=%h q=%0b, expected done=%0b lo=%h hi=%h q=%0b",
                     tag, out_done, res_lo, res_hi, q_flag, m_done, m_lo, m_hi, m_q);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] acc,
                        input logic clr, input logic wr, input logic wv, input string tag);
        logic [31:0] lo, hi;
        logic ov;
        in_valid = v; op_sel = op; src_a = a; src_b = b; acc_in = acc;
        q_clear = clr; q_wr_en = wr; q_wr_val = wv;
        model(op, a, b, acc, lo, hi, ov);
        @(posedge clk);
        m_done = v;
        if (v) begin
            m_lo = lo;
            m_hi = hi;
        end
        if (v && ov)   m_q = 1'b1;
        else if (clr)  m_q = 1'b0;
        else if (wr)   m_q = wv;
        @(negedge clk);
        in_valid = 1'b0; q_clear = 1'b0; q_wr_en = 1'b0;
        compare(tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R3: four pairings with halves of differing sign/magnitude
        for (int k = 0; k < 4; k++)
            step(1, 4'(k), 32'h8001_7FFF, 32'hFFFE_0003, 32'h1234_5678, 0, 0, 0, "R3 halfword mul");
        for (int k = 0; k < 4; k++)
            step(1, 4'(k), 32'h0005_FFF9, 32'hC000_8000, 32'h0, 0, 0, 0, "R3 signs");
        step(0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 0, 0, "R2 idle hold");
        step(0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 0, 0, "R2 idle hold");

        // R4: accumulate, in range
        for (int k = 4; k < 8; k++)
            step(1, 4'(k), 32'h8001_7FFF, 32'hFFFE_0003, 32'hFFFF_FF00, 0, 0, 0, "R4 halfword mac");

        // R5: overflow sets Q, result wraps
        step(1, 4'd4, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 0, 0, "R5 positive overflow");
        step(1, 4'd4, 32'h0000_0001, 32'h0000_0002, 32'h0000_0010, 0, 0, 0, "R5 sticky");
        step(1, 4'd0, 32'h0000_0003, 32'h0000_0004, 32'h0, 0, 0, 0, "R8 mul leaves Q set");
        step(0, 4'd0, 32'h0, 32'h0, 32'h0, 1, 0, 0, "R10 clear");
        step(1, 4'd7, 32'h8000_0000, 32'h7FFF_0000, 32'h8000_0000, 0, 0, 0, "R5 negative overflow");
        step(1, 4'd3, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 1, 0, 0, "R8 mul with clear");
        step(1, 4'd1, 32'h0000_8000, 32'h8000_0000, 32'h0, 0, 0, 0, "R8 mul no flag change");

        // R10 priorities
        step(0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 1, 1, "R10 write one");
        step(0, 4'd0, 32'h0, 32'h0, 32'h0, 1, 1, 1, "R10 clear beats write");
        step(1, 4'd4, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 1, 0, "R10 set beats write");
        step(1, 4'd4, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 1, 0, 0, "R10 set beats clear");
        step(0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 1, 0, "R10 write zero");

        // R6: word x halfword
        step(1, 4'd8, 32'h1234_5678, 32'hABCD_8001, 32'hFEDC_BA98, 0, 0, 0, "R6 word x bottom");
        step(1, 4'd9, 32'h1234_5678, 32'hABCD_8001, 32'hFEDC_BA98, 0, 0, 0, "R6 word x top");
        step(1, 4'd8, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_0000, 0, 0, 0, "R6 arithmetic shift");
        step(1, 4'd8, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 0, 0, "R6 overflow");
        step(0, 4'd0, 32'h0, 32'h0, 32'h0, 1, 0, 0, "R10 clear");
        step(1, 4'd9, 32'h8000_0000, 32'h7FFF_0000, 32'h8000_0000, 0, 0, 0, "R6 negative overflow");

        // R7: long multiply
        step(1, 4'd10, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0, 0, 0, 0, "R7 neg x pos");
        step(1, 4'd10, 32'h8000_0000, 32'h8000_0000, 32'h0, 0, 0, 0, "R7 min x min");
        step(1, 4'd10, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0, 0, 0, 0, "R7 mixed");
        step(1, 4'd5, 32'h0000_0002, 32'h0003_0000, 32'h0, 0, 0, 0, "R11 hi cleared");

        // R9: unused codes
        step(0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 1, 1, "R10 write one");
        for (int k = 11; k < 16; k++)
            step(1, 4'(k), 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 0, 0, 0, "R9 unused code");
        step(0, 4'd0, 32'h0, 32'h0, 32'h0, 0, 0, 0, "R2 done drops");

        summary();
        $finish;
    end

endmodule